// File: doc/BRIEF.md
# Word Load/Store Address and Alignment Unit

This unit sits between a core's register operands and a 32-bit data memory and handles whole-word transfers. For each request it adds a sign-extended 16-bit byte displacement to a 32-bit base value to form a byte address. It checks that this address falls on a four-byte boundary and then issues a word-indexed command to the memory. The memory's byte lanes are laid out little-end first (lane k holds bits [8k+7:8k]). Because the core numbers the bytes of a word most significant first, the unit reverses the lane order in both directions. A register's top byte therefore lands at the lowest byte address of the word.

A request whose address is not a multiple of four is rejected. The unit raises a one-cycle error flag and issues no memory command, so the address is never silently rounded down. Loads and stores form their address in exactly the same way and differ only in the direction of the transfer. Read data comes back through a registered return stage with a valid strobe.

Top module: `word_ldst_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_en, mem_we, misalign_err and load_valid are 0, and mem_addr, mem_wdata and load_word are all zero.
- R2: The byte address is base_addr plus byte_offset, taken modulo 2^32. When the request is sampled at edge n, mem_addr carries address bits [31:2] (the word index) after edge n.
- R3: byte_offset is a two's-complement value and is sign-extended before the addition. An offset with bit 15 set moves the address downward, and an address that runs past the top of the space wraps to the bottom.
- R4: If the address has either of bits [1:0] set, misalign_err is 1 for exactly the one cycle after edge n. In that cycle mem_en and mem_we are 0.
- R5: For an aligned store (req_store=1), mem_en=1 and mem_we=1 after edge n. mem_wdata is store_word with its bytes reversed: store_word[31:24] (byte 0) appears on mem_wdata[7:0], and store_word[7:0] (byte 3) appears on mem_wdata[31:24].
- R6: For an aligned load (req_store=0), mem_en=1 and mem_we=0 after edge n. The memory samples at edge n+1 and drives mem_rdata after it. After edge n+2, load_valid is 1 for one cycle and load_word is mem_rdata with its bytes reversed, so a stored word reads back unchanged.
- R7: A misaligned store writes nothing, and a misaligned load produces no load_valid. The word at the rounded-down address keeps its old value.
- R8: A cycle with req_valid=0 produces mem_en=0 and misalign_err=0 after the next edge.
- R9: load_word keeps its last value while load_valid is 0.
- R10: A request is accepted on every cycle. A load issued in the cycle right after a store to the same word returns the newly stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| base_addr | input | 32 | Base register value |
| byte_offset | input | 16 | Signed byte displacement |
| store_word | input | 32 | Word to store, byte 0 in bits [31:24] |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Word index (byte address bits [31:2]) |
| mem_wdata | output | 32 | Write data, lane k at bits [8k+7:8k] |
| mem_rdata | input | 32 | Read data, valid one cycle after a read command |
| load_valid | output | 1 | load_word holds a completed load |
| load_word | output | 32 | Loaded word, byte 0 in bits [31:24] |
| misalign_err | output | 1 | Pulse: last request was misaligned |

## Verification
A wrong adder or sign extension shows up on mem_addr in the first cycle after the request. A lost alignment check shows up in the same cycle as a stray mem_en or mem_we together with a missing error pulse. A wrong lane order shows on mem_wdata at once. The same fault shows as a corrupted word two edges later, when a stored value is read back. A stuck or missing read-pending flag shows as a load_valid strobe that is absent or extra two edges after the command. A rounded-down misaligned write only becomes visible when the affected word is loaded later.

// File: rtl/word_ldst_pkg.sv
package word_ldst_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic {
    XFER_LOAD  = 1'b0,
    XFER_STORE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/ldst_eaddr_gen.sv
module ldst_eaddr_gen #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ADDR_W-1:0]            base_addr,
  input  logic [OFF_W-1:0]             byte_offset,
  output logic [ADDR_W-ALIGN_BITS-1:0] word_idx,
  output logic                         misaligned
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] offset_ext;
  logic [ADDR_W-1:0] byte_addr;

  // R3: two's-complement displacement widened with its sign bit
  assign offset_ext = {{EXT_W{byte_offset[OFF_W-1]}}, byte_offset};
  // R2: modulo-2^ADDR_W byte address
  assign byte_addr  = base_addr + offset_ext;
  assign word_idx   = byte_addr[ADDR_W-1:ALIGN_BITS];
  // R4: any set low bit breaks word alignment
  assign misaligned = |byte_addr[ALIGN_BITS-1:0];
endmodule

// File: rtl/ldst_lane_order.sv
module ldst_lane_order
  import word_ldst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / BYTE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (BIG_ENDIAN) begin : g_rev
      assign dout[BYTE_W*k +: BYTE_W] = din[BYTE_W*(LANES-1-k) +: BYTE_W];
    end else begin : g_fwd
      assign dout[BYTE_W*k +: BYTE_W] = din[BYTE_W*k +: BYTE_W];
    end
  end
endmodule

// File: rtl/ldst_cmd_stage.sv
module ldst_cmd_stage
  import word_ldst_pkg::*;
#(
  parameter int WIDX_W = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              misaligned,
  input  logic [WIDX_W-1:0] word_idx,
  input  logic [DATA_W-1:0] wr_lanes,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WIDX_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign_err
);
  logic go;
  logic is_store;

  assign is_store = (xfer_dir_e'(req_store) == XFER_STORE);
  assign go       = req_valid && !misaligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      misalign_err <= 1'b0;
    end else begin
      mem_en       <= go;
      mem_we       <= go && is_store;
      misalign_err <= req_valid && misaligned;
      if (go) mem_addr <= word_idx;
      if (go && is_store) mem_wdata <= wr_lanes;
    end
  end

  // R4: a rejected request never reaches memory
  p_err_no_mem_r4: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!mem_en && !mem_we))
    else $error("misaligned access reached memory");

  // R4: error pulse only follows a request
  p_err_from_req_r4: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> $past(req_valid))
    else $error("error without request");

  // R5: write strobe implies an access
  p_we_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en)
    else $error("write without enable");

  // R8: idle cycle leaves memory quiet
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!mem_en && !misalign_err))
    else $error("activity without request");
endmodule

// File: rtl/ldst_load_return.sv
module ldst_load_return #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] rd_lanes,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_word
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend    <= 1'b0;
      load_valid <= 1'b0;
      load_word  <= '0;
    end else begin
      rd_pend    <= cmd_en && !cmd_we;
      load_valid <= rd_pend;
      if (rd_pend) load_word <= rd_lanes;
    end
  end

  // R9: returned word only moves with a strobe
  p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
    !load_valid |-> $stable(load_word))
    else $error("load word changed without strobe");
endmodule

// File: rtl/word_ldst_unit.sv
module word_ldst_unit #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b1,
  localparam int LANES      = DATA_W / 8,
  localparam int ALIGN_BITS = $clog2(LANES),
  localparam int WIDX_W     = ADDR_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  byte_offset,
  input  logic [DATA_W-1:0] store_word,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WIDX_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_word,
  output logic              misalign_err
);
  logic [WIDX_W-1:0] word_idx;
  logic              misaligned;
  logic [DATA_W-1:0] wr_lanes;
  logic [DATA_W-1:0] rd_lanes;

  ldst_eaddr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_eaddr (
    .base_addr(base_addr), .byte_offset(byte_offset),
    .word_idx(word_idx), .misaligned(misaligned)
  );

  ldst_lane_order #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_wr_order (
    .din(store_word), .dout(wr_lanes)
  );

  ldst_lane_order #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_rd_order (
    .din(mem_rdata), .dout(rd_lanes)
  );

  ldst_cmd_stage #(.WIDX_W(WIDX_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .misaligned(misaligned), .word_idx(word_idx), .wr_lanes(wr_lanes),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .misalign_err(misalign_err)
  );

  ldst_load_return #(.DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst(rst), .cmd_en(mem_en), .cmd_we(mem_we),
    .rd_lanes(rd_lanes), .load_valid(load_valid), .load_word(load_word)
  );

  // R6: a load strobe is always two edges behind a read command
  p_load_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(mem_en && !mem_we, 2))
    else $error("load strobe without read command");

  // R7: error and load strobe come from different requests only
  p_no_load_on_err_r7: assert property (@(posedge clk) disable iff (rst)
    $past(misalign_err, 2) && !$past(mem_en, 2) |-> !load_valid)
    else $error("load strobe after rejected request");
endmodule

// File: tb/word_ldst_unit_tb_top.sv
`timescale 1ns/1ps
module word_ldst_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] byte_offset = '0;
  logic [31:0] store_word = '0;
  logic        mem_en, mem_we, load_valid, misalign_err;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, load_word;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  word_ldst_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .base_addr(base_addr), .byte_offset(byte_offset), .store_word(store_word),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
    .load_word(load_word), .misalign_err(misalign_err)
  );

  // one-cycle synchronous memory model, lane k at bits [8k+7:8k]
  logic [31:0] bmem [1024];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[9:0]];
    end
  end

  function automatic logic [31:0] lanes_of(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        st;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] wd;
    logic        err;
    logic [29:0] widx;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 16'h0020, 32'h1122_3344, 1'b0, 30'h408, 32'h0},
    '{1'b1, 32'h0000_1040, 16'hFFFC, 32'hA1B2_C3D4, 1'b0, 30'h40F, 32'h0},
    '{1'b1, 32'h0000_0FFE, 16'h0002, 32'hDEAD_BEEF, 1'b0, 30'h400, 32'h0},
    '{1'b1, 32'h0000_1000, 16'h0001, 32'h5555_5555, 1'b1, 30'h0,   32'h0},
    '{1'b0, 32'h0000_1000, 16'h0020, 32'h0,         1'b0, 30'h408, 32'h1122_3344},
    '{1'b0, 32'h0000_1003, 16'h0000, 32'h0,         1'b1, 30'h0,   32'h0},
    '{1'b1, 32'hFFFF_FFFC, 16'h0008, 32'h0BAD_F00D, 1'b0, 30'h001, 32'h0},
    '{1'b0, 32'h0000_903C, 16'h8000, 32'h0,         1'b0, 30'h40F, 32'hA1B2_C3D4},
    '{1'b0, 32'h0000_1004, 16'hFFFC, 32'h0,         1'b0, 30'h400, 32'hDEAD_BEEF}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!mem_en && !mem_we && !misalign_err && !load_valid, "R1 ctrl",
          {mem_en, mem_we, misalign_err, load_valid}, 0);
    check(mem_addr == 0 && mem_wdata == 0 && load_word == 0, "R1 data",
          {mem_addr, mem_wdata}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_en && !misalign_err && !load_valid, "R1 post", {mem_en, misalign_err}, 0);

    for (int i = 0; i < NV; i++) begin
      req_valid   = 1'b1;
      req_store   = VECS[i].st;
      base_addr   = VECS[i].base;
      byte_offset = VECS[i].off;
      store_word  = VECS[i].wd;
      @(negedge clk);
      req_valid = 1'b0;
      // R4 R5 R6 R7: command cycle
      check(misalign_err == VECS[i].err, "R4 err", misalign_err, VECS[i].err);
      check(mem_en == !VECS[i].err, "R7 en", mem_en, !VECS[i].err);
      check(mem_we == (VECS[i].st && !VECS[i].err), "R5 we", mem_we, VECS[i].st);
      if (!VECS[i].err)
        check(mem_addr == VECS[i].widx, "R2 R3 addr", mem_addr, VECS[i].widx);
      if (VECS[i].st && !VECS[i].err)
        check(mem_wdata == lanes_of(VECS[i].wd), "R5 lanes", mem_wdata,
              lanes_of(VECS[i].wd));
      @(negedge clk);
      check(!misalign_err && !mem_en, "R4 one-cycle", {misalign_err, mem_en}, 0);
      check(!load_valid, "R6 early", load_valid, 0);
      @(negedge clk);
      check(load_valid == (!VECS[i].st && !VECS[i].err), "R6 R7 valid",
            load_valid, !VECS[i].st && !VECS[i].err);
      if (!VECS[i].st && !VECS[i].err)
        check(load_word == VECS[i].ld, "R6 R7 data", load_word, VECS[i].ld);
    end

    // R9: load_word holds (last load returned DEADBEEF)
    repeat (2) @(negedge clk);
    check(!load_valid && load_word == 32'hDEAD_BEEF, "R9 hold", load_word,
          32'hDEAD_BEEF);
    check(!mem_en && !misalign_err, "R8 idle", {mem_en, misalign_err}, 0);

    // R10: store then load back to back
    req_valid = 1'b1; req_store = 1'b1; base_addr = 32'h0000_0100;
    byte_offset = 16'h0000; store_word = 32'h600D_CAFE;
    @(negedge clk);
    req_store = 1'b0; store_word = 32'h0;
    check(mem_we && mem_addr == 30'h040, "R10 store", {mem_we, mem_addr}, 30'h40);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_en && !mem_we && mem_addr == 30'h040, "R10 load cmd", mem_addr, 30'h40);
    @(negedge clk);
    check(!load_valid, "R10 early", load_valid, 0);
    @(negedge clk);
    check(load_valid && load_word == 32'h600D_CAFE, "R10 data", load_word,
          32'h600D_CAFE);
    @(negedge clk);
    check(!load_valid, "R6 single strobe", load_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule